// File: doc/BRIEF.md
# Register-Driven Bit-Bang SPI Port

This block is a memory-mapped SPI port in which software moves the serial pins itself. A 32-bit register bus writes pin values into a pin-control register: one bit for the serial clock, one for the serial data output and one for each of three chip selects. A mode bit in a function-select register decides who owns the pins. When the mode is on, the pins follow the pin-control register. When it is off, the pins follow a separate memory-mapped read engine, which reaches the block through dedicated inputs. Writes made in that state are still stored.

Software runs SPI mode 0 by hand. The clock rests low. Software sets the data-out bit while the clock is low and then writes the clock bit high. On each such rising write, the hardware moves the level on the serial data input into a 32-bit receive-shift register. Software reads that register back when the word is complete. A control register is plain storage, so that software can save its value and put it back later. Register reads are combinational from the address.

Top module: `spi_pin_port`

## Requirements
- R1: After synchronous reset, every mapped register reads zero and the serial clock, data-out and all chip-select outputs are low (the mode bit is off, so the engine inputs are driven to the pins).
- R2: Offset 0x00 holds the mode bit at bit 0. It is readable and writable, and bits 31..1 always read zero.
- R3: Offset 0x04 is a 32-bit control register that reads back exactly the last value written.
- R4: Offset 0x08 is the pin-control register. It stores bit 0 (data out), bit 8 (clock) and bits 16, 17 and 18 (chip selects 0, 1 and 2), and all other bits read zero.
- R5: With the mode bit set, data out equals pin-control bit 0, the clock equals bit 8, and chip select n equals bit 16+n, with no inversion.
- R6: With the mode bit clear, the clock, data-out and chip-select outputs equal the engine inputs. Pin-control writes are stored and read back but do not reach the pins.
- R7: A write to offset 0x08 with the mode bit set, where bit 8 goes from 0 to 1, shifts the serial data input level into bit 0 of the receive-shift register. All older bits move one place toward bit 31.
- R8: The receive-shift register keeps its value on pin-control writes that keep the clock bit high, lower it, or occur while the mode bit is clear.
- R9: Offset 0x0C reads the receive-shift register, and writes to offset 0x0C change nothing.
- R10: Reads of any offset other than 0x00, 0x04, 0x08 and 0x0C return zero, and writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Byte offset of the register access |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| din | input | 1 | Serial data input from the slave |
| eng_sck | input | 1 | Clock from the memory-mapped read engine |
| eng_mosi | input | 1 | Data out from the read engine |
| eng_cs | input | 3 | Chip selects from the read engine |
| sck | output | 1 | Serial clock pin |
| mosi | output | 1 | Serial data output pin |
| cs | output | 3 | Chip-select pins, polarity as written |

## Verification
The bench watches the shift register around each pin-control write.

- **Shift only on a rising write.** A design that shifted on every write with the clock bit high would double-count. So would one that also shifted on falling writes. A design that shifted while the mode bit was off would pick up stray bits. Each of these leaves a receive word different from the arithmetic model.
- **More than 32 bits.** Shifting past 32 bits checks that old bits leave at the top and that the newest bit lands at bit 0. A reversed shift would fail this check.
- **Stored but not driven.** With the mode bit off, pin writes must read back while the engine inputs stay on the pins. A design that drove them through would show the written values on the pins.
- **Every unmapped offset.** The bench writes and reads each of the 60 unmapped offsets. An incomplete decode would either return stale data there or overwrite a real register.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;

    localparam int DW   = 32;
    localparam int CS_N = 3;

    localparam logic [7:0] OFF_FUNC = 8'h00;
    localparam logic [7:0] OFF_CTRL = 8'h04;
    localparam logic [7:0] OFF_PIN  = 8'h08;
    localparam logic [7:0] OFF_RX   = 8'h0C;

    localparam int BIT_MODE = 0;
    localparam int BIT_MOSI = 0;
    localparam int BIT_SCK  = 8;
    localparam int BIT_CS0  = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FUNC,
        SEL_CTRL,
        SEL_PIN,
        SEL_RX
    } reg_sel_e;

    typedef struct packed {
        logic            sck;
        logic            mosi;
        logic [CS_N-1:0] cs;
    } pins_t;

    function automatic pins_t pins_from_word(logic [DW-1:0] w);
        pins_t p;
        p.sck  = w[BIT_SCK];
        p.mosi = w[BIT_MOSI];
        p.cs   = w[BIT_CS0 +: CS_N];
        return p;
    endfunction

    function automatic logic [DW-1:0] word_from_pins(pins_t p);
        logic [DW-1:0] w;
        w = '0;
        w[BIT_SCK]          = p.sck;
        w[BIT_MOSI]         = p.mosi;
        w[BIT_CS0 +: CS_N]  = p.cs;
        return w;
    endfunction

    function automatic reg_sel_e decode(logic [7:0] off);
        case (off)
            OFF_FUNC: return SEL_FUNC;
            OFF_CTRL: return SEL_CTRL;
            OFF_PIN:  return SEL_PIN;
            OFF_RX:   return SEL_RX;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_regs.sv
module spi_pin_regs
    import spi_pin_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    output logic          mode,
    output logic [DW-1:0] ctrl_q,
    output pins_t         pins_q,
    output logic          sck_rise
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= 1'b0;
            ctrl_q <= '0;
            pins_q <= '0;
        end else if (we) begin
            case (sel)
                SEL_FUNC: mode   <= wdata[BIT_MODE];
                SEL_CTRL: ctrl_q <= wdata;
                SEL_PIN:  pins_q <= pins_from_word(wdata);
                default:  ;
            endcase
        end
    end

    // A rising edge on the clock bit, made by software while it owns the pins
    assign sck_rise = we && (sel == SEL_PIN) && mode && !pins_q.sck && wdata[BIT_SCK];

    AST_PIN_STORED: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_PIN) |=> (word_from_pins(pins_q) == word_from_pins(pins_from_word($past(wdata))))); // R6

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (we && (sel == SEL_NONE || sel == SEL_RX)) |=> ($stable(mode) && $stable(ctrl_q) && $stable(pins_q))); // R10

endmodule

// File: rtl/spi_pin_rxshift.sv
module spi_pin_rxshift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] rx_q
);

    always_ff @(posedge clk) begin
        if (rst)
            rx_q <= '0;
        else if (shift_en)
            rx_q <= {rx_q[W-2:0], din};
    end

    AST_SHIFT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (rx_q[0] == $past(din) && rx_q[W-1:1] == $past(rx_q[W-2:0]))); // R7

    AST_HOLD_WITHOUT_RISE: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(rx_q)); // R8

endmodule

// File: rtl/spi_pin_port.sv
module spi_pin_port
    import spi_pin_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              din,
    input  logic              eng_sck,
    input  logic              eng_mosi,
    input  logic [CS_N-1:0]   eng_cs,
    output logic              sck,
    output logic              mosi,
    output logic [CS_N-1:0]   cs
);

    localparam int OFF_W = 8;

    reg_sel_e      sel;
    logic          mode;
    logic [DW-1:0] ctrl_q;
    pins_t         pins_q;
    pins_t         pins_eng;
    pins_t         pins_out;
    logic          sck_rise;
    logic [DW-1:0] rx_q;

    assign sel = decode(OFF_W'(addr));

    spi_pin_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .sel      (sel),
        .wdata    (wdata),
        .mode     (mode),
        .ctrl_q   (ctrl_q),
        .pins_q   (pins_q),
        .sck_rise (sck_rise)
    );

    spi_pin_rxshift #(.W(DW)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sck_rise),
        .din      (din),
        .rx_q     (rx_q)
    );

    // Pin ownership: register bits in bit-bang mode, read engine otherwise
    always_comb begin
        pins_eng.sck  = eng_sck;
        pins_eng.mosi = eng_mosi;
        pins_eng.cs   = eng_cs;
        pins_out      = mode ? pins_q : pins_eng;
    end

    assign sck  = pins_out.sck;
    assign mosi = pins_out.mosi;
    assign cs   = pins_out.cs;

    always_comb begin
        case (sel)
            SEL_FUNC: rdata = DW'(mode);
            SEL_CTRL: rdata = ctrl_q;
            SEL_PIN:  rdata = word_from_pins(pins_q);
            SEL_RX:   rdata = rx_q;
            default:  rdata = '0;
        endcase
    end

    AST_FUNC_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_FUNC) |-> (rdata[DW-1:1] == '0)); // R2

    AST_RX_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_RX) |=> $stable(rx_q)); // R9

    AST_NO_SHIFT_MODE_OFF: assert property (@(posedge clk) disable iff (rst)
        (we && !mode) |=> $stable(rx_q)); // R8

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (rdata == '0)); // R10

endmodule

// File: tb/spi_pin_port_test.sv
module spi_pin_port_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        din;
    logic        eng_sck;
    logic        eng_mosi;
    logic [2:0]  eng_cs;
    logic        sck;
    logic        mosi;
    logic [2:0]  cs;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_rx;
    logic        exp_sck_bit;

    always #10 clk = ~clk;

    spi_pin_port uut (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
        .din(din), .eng_sck(eng_sck), .eng_mosi(eng_mosi), .eng_cs(eng_cs),
        .sck(sck), .mosi(mosi), .cs(cs)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d, logic dv);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1; din = dv;
        @(negedge clk);
        we = 1'b0;
        #1;
    endtask

    task automatic rd(string req, logic [5:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic pins_chk(string req, logic es, logic em, logic [2:0] ec);
        chk(req, {27'd0, sck, mosi, cs}, {27'd0, es, em, ec});
    endtask

    // bit-bang mode pin write with model of the receive shift
    task automatic pin_wr(logic [31:0] d, logic dv);
        if (!exp_sck_bit && d[8]) exp_rx = {exp_rx[30:0], dv};
        exp_sck_bit = d[8];
        wr(6'h08, d, dv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr = '0; we = 1'b0; wdata = '0; din = 1'b0;
        eng_sck = 1'b0; eng_mosi = 1'b0; eng_cs = 3'b000;
        exp_rx = '0; exp_sck_bit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        pins_chk("R1 pins", 1'b0, 1'b0, 3'b000);
        rd("R1 func", 6'h00, 32'h0);
        rd("R1 ctrl", 6'h04, 32'h0);
        rd("R1 pin", 6'h08, 32'h0);
        rd("R1 rx", 6'h0C, 32'h0);

        // R2: mode bit only
        wr(6'h00, 32'hFFFF_FFFE, 1'b0);
        rd("R2 func", 6'h00, 32'h0);
        wr(6'h00, 32'hFFFF_FFFF, 1'b0);
        rd("R2 func", 6'h00, 32'h1);
        wr(6'h00, 32'h0, 1'b0);
        rd("R2 func", 6'h00, 32'h0);

        // R3: control storage
        wr(6'h04, 32'hA5A5_5A5A, 1'b0); rd("R3 ctrl", 6'h04, 32'hA5A5_5A5A);
        wr(6'h04, 32'hFFFF_FFFF, 1'b0); rd("R3 ctrl", 6'h04, 32'hFFFF_FFFF);
        wr(6'h04, 32'h1234_5678, 1'b0); rd("R3 ctrl", 6'h04, 32'h1234_5678);

        // R6: engine owns pins while mode is off
        for (int v = 0; v < 32; v++) begin
            @(negedge clk);
            eng_sck = v[4]; eng_mosi = v[3]; eng_cs = v[2:0];
            #1;
            pins_chk("R6 engine", v[4], v[3], v[2:0]);
        end
        eng_sck = 1'b0; eng_mosi = 1'b1; eng_cs = 3'b010;
        // R4 R6 R8: stored, not driven, no shift while mode off
        wr(6'h08, 32'hFFFF_FFFF, 1'b1);
        rd("R4 pin mask", 6'h08, 32'h0007_0101);
        pins_chk("R6 not driven", 1'b0, 1'b1, 3'b010);
        rd("R8 rx mode off", 6'h0C, 32'h0);
        exp_sck_bit = 1'b1;

        // R5: mode on, pins follow register
        wr(6'h00, 32'h1, 1'b0);
        pins_chk("R5 drive", 1'b1, 1'b1, 3'b111);
        pin_wr(32'h0, 1'b1);   // falling clock bit: no shift
        rd("R8 fall", 6'h0C, exp_rx);

        // R5 R7 R8: sweep all pin combinations with shift model
        for (int v = 0; v < 32; v++) begin
            logic [31:0] w;
            w = {13'd0, v[2:0], 7'd0, v[4], 7'd0, v[3]};
            pin_wr(w, v[0] ^ v[3]);
            pins_chk("R5 sweep", v[4], v[3], v[2:0]);
            rd("R7 sweep rx", 6'h0C, exp_rx);
        end

        // R7: long serial stream, 40 bits
        for (int i = 0; i < 40; i++) begin
            logic b;
            b = ((i * 7 + 3) % 5) < 2;
            pin_wr(32'h0001_0000 | 32'(b), 1'b0);
            pin_wr(32'h0001_0100 | 32'(b), b);
            if (i == 31 || i == 39) rd("R7 stream", 6'h0C, exp_rx);
        end
        // R8: clock bit kept high
        pin_wr(32'h0001_0100, ~exp_rx[0]);
        rd("R8 stay high", 6'h0C, exp_rx);

        // R9: rx write ignored
        wr(6'h0C, 32'hDEAD_BEEF, 1'b1);
        rd("R9 rx", 6'h0C, exp_rx);

        // R10: unmapped offsets
        for (int a = 0; a < 64; a++) begin
            if (a != 0 && a != 4 && a != 8 && a != 12) begin
                wr(6'(a), 32'hFFFF_FFFF, 1'b1);
                rd("R10 unmapped", 6'(a), 32'h0);
            end
        end
        rd("R10 func kept", 6'h00, 32'h1);
        rd("R10 ctrl kept", 6'h04, 32'h1234_5678);
        rd("R10 pin kept", 6'h08, 32'h0001_0100);
        rd("R10 rx kept", 6'h0C, exp_rx);

        // R6 R8: back to engine, rising write ignored
        pin_wr(32'h0, 1'b0);
        wr(6'h00, 32'h0, 1'b0);
        eng_sck = 1'b1; eng_mosi = 1'b0; eng_cs = 3'b101;
        wr(6'h08, 32'h0002_0100, 1'b1);
        pins_chk("R6 off again", 1'b1, 1'b0, 3'b101);
        rd("R8 off rise", 6'h0C, exp_rx);
        rd("R6 stored", 6'h08, 32'h0002_0100);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule